// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data addresses for a DSP datapath. It keeps four index pointers. Each pointer has its own modify, length and base register. On an indirect access the selected pointer goes straight out as the address in the same cycle. At the clock edge that ends the access, the pointer is post-modified by a signed step taken from any one of the four modify registers.

When the pointer's length register is nonzero, the update stays inside a circular buffer that starts at the pointer's base and spans the length. When the length is zero, the pointer moves linearly, modulo the address width.

A mode input can emit the low address bits in reverse order for FFT-style access. Only the emitted address is reversed; the stored pointer is not. A single register-write port loads all sixteen registers.

Top module: `circAddrGen`

## Requirements
- R1: After reset every pointer, modify, length and base register is zero, so an access to any pointer emits address 0.
- R2: A write with wrEn high loads wrData into the register picked by wrKind and wrIdx. The wrKind codes are 0 = pointer, 1 = modify, 2 = length and 3 = base. The new value is used from the next cycle on.
- R3: While accEn is high and revMode is low, addr equals the pointer selected by accIdx in that same cycle, with no register in the path.
- R4: At the edge that ends an access, only the accessed pointer is replaced by its post-modified value. The step is the modify register picked by modIdx, read as two's complement. The other three pointers keep their values.
- R5: With a length of zero the post-modified pointer is (pointer + modify) mod 2^AW.
- R6: With a nonzero length L and base B, a sum at or above B+L is reduced by L and a sum below B is raised by L. Any other sum is kept as is. With |modify| < L and the pointer inside the buffer, the result stays in [B, B+L).
- R7: When BITREV_EN is set and revMode is high, bits REV_W-1..0 of the emitted address are the selected pointer's low bits in reverse order, and the bits above pass through. The stored pointer and its update are unaffected.
- R8: A pointer write and an access to the same pointer in one cycle leave the written value in the pointer; no post-modify is applied.
- R9: A pointer that is neither written nor accessed holds its value across any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | Register kind: 0 pointer, 1 modify, 2 length, 3 base |
| wrIdx | input | 2 | Slot written |
| wrData | input | AW | Write value (modify is two's complement) |
| accEn | input | 1 | Indirect access strobe |
| accIdx | input | 2 | Pointer used for the access |
| modIdx | input | 2 | Modify register used for the post-modify |
| revMode | input | 1 | Emit the address bit-reversed |
| addr | output | AW | Emitted address |

## Verification
The range assertion on circular updates applies only when the buffer fits in the address space (B+L ≤ 2^AW), the step magnitude is below L, and the pointer already lies inside its buffer. Outside those conditions the wrap result is defined but not bounded. The bench's circular sweep keeps every base and length pair within the address space, and it tries every legal step against every in-buffer starting position. Linear behaviour is driven only with zero lengths, where the assertions make no range assumption.

// File: rtl/dagPkg.sv
package dagPkg;
  localparam int SLOTS = 4;
  localparam int SEL_W = $clog2(SLOTS);

  typedef enum logic [1:0] {
    KIND_PTR  = 2'd0,
    KIND_MOD  = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_BASE = 2'd3
  } regKind_e;

  typedef struct packed {
    logic [SLOTS-1:0] ldPtr;
    logic [SLOTS-1:0] ldMod;
    logic [SLOTS-1:0] ldLen;
    logic [SLOTS-1:0] ldBase;
    logic [SLOTS-1:0] step;
    logic [SEL_W-1:0] ptrSel;
    logic [SEL_W-1:0] modSel;
  } dagStrobes_t;
endpackage

// File: rtl/dagCtrl.sv
module dagCtrl
  import dagPkg::*;
(
  input  logic             wrEn,
  input  logic [1:0]       wrKind,
  input  logic [SEL_W-1:0] wrIdx,
  input  logic             accEn,
  input  logic [SEL_W-1:0] accIdx,
  input  logic [SEL_W-1:0] modIdx,
  output dagStrobes_t      strobes
);
  logic [SLOTS-1:0] accHit;

  always_comb begin
    strobes        = '0;
    strobes.ptrSel = accIdx;
    strobes.modSel = modIdx;
    if (wrEn) begin
      case (regKind_e'(wrKind))
        KIND_PTR:  strobes.ldPtr[wrIdx]  = 1'b1;
        KIND_MOD:  strobes.ldMod[wrIdx]  = 1'b1;
        KIND_LEN:  strobes.ldLen[wrIdx]  = 1'b1;
        KIND_BASE: strobes.ldBase[wrIdx] = 1'b1;
        default:   ;
      endcase
    end
    accHit = '0;
    if (accEn) accHit[accIdx] = 1'b1;
    // a pointer write overrides the post-modify of the same slot
    strobes.step = accHit & ~strobes.ldPtr;
  end
endmodule

// File: rtl/dagPath.sv
module dagPath
  import dagPkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rstN,
  input  dagStrobes_t   strobes,
  input  logic [AW-1:0] wrData,
  output logic [AW-1:0] curPtr
);
  localparam int XW = AW + 2;

  logic [SLOTS-1:0][AW-1:0] ptrQ, modQ, lenQ, baseQ;
  logic [AW-1:0] curMod, curLen, curBase, nextPtr;
  logic signed [XW-1:0] sumX, baseX, lenX, endX, wrapX;

  assign curPtr  = ptrQ[strobes.ptrSel];
  assign curMod  = modQ[strobes.modSel];
  assign curLen  = lenQ[strobes.ptrSel];
  assign curBase = baseQ[strobes.ptrSel];

  always_comb begin
    sumX  = $signed({2'b00, curPtr}) + $signed({{2{curMod[AW-1]}}, curMod});
    baseX = $signed({2'b00, curBase});
    lenX  = $signed({2'b00, curLen});
    endX  = baseX + lenX;
    if (curLen == '0)       wrapX = sumX;
    else if (sumX >= endX)  wrapX = sumX - lenX;
    else if (sumX < baseX)  wrapX = sumX + lenX;
    else                    wrapX = sumX;
    nextPtr = wrapX[AW-1:0];
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrQ[k]  <= '0;
        modQ[k]  <= '0;
        lenQ[k]  <= '0;
        baseQ[k] <= '0;
      end else begin
        if (strobes.ldPtr[k])     ptrQ[k] <= wrData;
        else if (strobes.step[k]) ptrQ[k] <= nextPtr;
        if (strobes.ldMod[k])  modQ[k]  <= wrData;
        if (strobes.ldLen[k])  lenQ[k]  <= wrData;
        if (strobes.ldBase[k]) baseQ[k] <= wrData;
      end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.ldPtr[k] && !strobes.step[k]) |=> $stable(ptrQ[k]));

    p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.ldPtr[k] |=> (ptrQ[k] == $past(wrData)));
  end

  // helpers for the circular-range check (R6)
  logic [AW:0]   bufEnd;
  logic [AW-1:0] modMag;
  logic          inBuf, bufFits, stepSmall;
  assign bufEnd    = {1'b0, curBase} + {1'b0, curLen};
  assign modMag    = curMod[AW-1] ? (~curMod + 1'b1) : curMod;
  assign inBuf     = (curPtr >= curBase) && ({1'b0, curPtr} < bufEnd);
  assign bufFits   = bufEnd <= {1'b1, {AW{1'b0}}};
  assign stepSmall = modMag < curLen;

  p_linear_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((|strobes.step) && curLen == '0)
    |=> (ptrQ[$past(strobes.ptrSel)] == AW'($past(curPtr) + $past(curMod))));

  p_wrap_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((|strobes.step) && curLen != '0 && inBuf && bufFits && stepSmall)
    |=> ((ptrQ[$past(strobes.ptrSel)] >= $past(curBase)) &&
         ({1'b0, ptrQ[$past(strobes.ptrSel)]} < $past(bufEnd))));
endmodule

// File: rtl/dagBitRev.sv
module dagBitRev #(
  parameter int AW        = 14,
  parameter int REV_W     = 14,
  parameter bit BITREV_EN = 1'b1
) (
  input  logic [AW-1:0] addrIn,
  input  logic          revMode,
  output logic [AW-1:0] addrOut
);
  if (BITREV_EN) begin : g_rev
    logic [AW-1:0] revAddr;
    for (genvar b = 0; b < REV_W; b++) begin : g_bit
      assign revAddr[b] = addrIn[REV_W-1-b];
    end
    if (REV_W < AW) begin : g_upper
      assign revAddr[AW-1:REV_W] = addrIn[AW-1:REV_W];
    end
    assign addrOut = revMode ? revAddr : addrIn;
  end else begin : g_plain
    assign addrOut = addrIn;
  end
endmodule

// File: rtl/circAddrGen.sv
module circAddrGen
  import dagPkg::*;
#(
  parameter int AW        = 14,
  parameter int REV_W     = 14,
  parameter bit BITREV_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrKind,
  input  logic [SEL_W-1:0] wrIdx,
  input  logic [AW-1:0]    wrData,
  input  logic             accEn,
  input  logic [SEL_W-1:0] accIdx,
  input  logic [SEL_W-1:0] modIdx,
  input  logic             revMode,
  output logic [AW-1:0]    addr
);
  dagStrobes_t   strobes;
  logic [AW-1:0] curPtr;

  dagCtrl i_ctrl (
    .wrEn(wrEn), .wrKind(wrKind), .wrIdx(wrIdx),
    .accEn(accEn), .accIdx(accIdx), .modIdx(modIdx),
    .strobes(strobes)
  );

  dagPath #(.AW(AW)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(wrData), .curPtr(curPtr)
  );

  dagBitRev #(.AW(AW), .REV_W(REV_W), .BITREV_EN(BITREV_EN)) i_rev (
    .addrIn(curPtr), .revMode(revMode), .addrOut(addr)
  );
endmodule

// File: tb/test_circAddrGen.sv
`timescale 1ns/1ps
module test_circAddrGen;
  localparam int AW = 8;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, accEn = 1'b0, revMode = 1'b0;
  logic [1:0] wrKind = '0, wrIdx = '0, accIdx = '0, modIdx = '0;
  logic [AW-1:0] wrData = '0;
  logic [AW-1:0] addr;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  circAddrGen #(.AW(AW), .REV_W(RW), .BITREV_EN(1'b1)) i_circAddrGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrIdx(wrIdx),
    .wrData(wrData), .accEn(accEn), .accIdx(accIdx), .modIdx(modIdx),
    .revMode(revMode), .addr(addr)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input int exp);
    vectors++;
    if (act !== exp[AW-1:0]) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp[AW-1:0]);
    end
  endtask

  task automatic wrReg(input int kind, input int idx, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrKind = kind[1:0]; wrIdx = idx[1:0]; wrData = val[AW-1:0];
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic accessCk(input int idx, input int mi, input logic rev,
                          input int exp, input string req);
    @(negedge clk);
    accEn = 1'b1; accIdx = idx[1:0]; modIdx = mi[1:0]; revMode = rev;
    #1 check(req, addr, exp);
    @(posedge clk); #1;
    accEn = 1'b0; revMode = 1'b0;
  endtask

  function automatic int stepExp(int p, int m, int b, int l);
    int s = p + m;
    if (l != 0) begin
      if (s >= b + l) s -= l;
      else if (s < b) s += l;
    end
    return s & ((1 << AW) - 1);
  endfunction

  function automatic int revExp(int p);
    int r = p & ~((1 << RW) - 1);
    for (int b = 0; b < RW; b++) if (p[b]) r |= 1 << (RW - 1 - b);
    return r & ((1 << AW) - 1);
  endfunction

  initial begin
    int bases[3] = '{0, 40, 200};
    int lens[4]  = '{1, 5, 16, 37};
    int steps[6] = '{-128, -1, 0, 1, 5, 127};
    int vec = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state, all modify registers zero so accesses do not move
    for (int k = 0; k < 4; k++) accessCk(k, k, 1'b0, 0, "R1");

    // R6 / R2 / R3: circular sweep over every in-buffer start and legal step
    foreach (bases[bi]) foreach (lens[li]) begin
      for (int k = 0; k < 4; k++) begin
        wrReg(3, k, bases[bi]);
        wrReg(2, k, lens[li]);
      end
      for (int off = 0; off < lens[li]; off++)
        for (int m = -(lens[li] - 1); m < lens[li]; m++) begin
          int idx = vec % 4;
          int mi  = (vec + 1) % 4;
          int p   = bases[bi] + off;
          wrReg(0, idx, p);
          wrReg(1, mi, m);
          accessCk(idx, mi, 1'b0, p, "R2,R3");
          accessCk(idx, mi, 1'b0, stepExp(p, m, bases[bi], lens[li]), "R6");
          vec++;
        end
    end

    // R5: zero length, linear modulo 2^AW
    for (int k = 0; k < 4; k++) wrReg(2, k, 0);
    for (int p = 0; p < 256; p += 15)
      foreach (steps[si]) begin
        int idx = vec % 4;
        int mi  = (vec + 2) % 4;
        wrReg(0, idx, p);
        wrReg(1, mi, steps[si]);
        accessCk(idx, mi, 1'b0, p, "R3");
        accessCk(idx, mi, 1'b0, stepExp(p, steps[si], 0, 0), "R5");
        vec++;
      end

    // R4: only the accessed pointer moves, by the selected modify
    wrReg(0, 0, 10); wrReg(0, 1, 20); wrReg(0, 2, 30); wrReg(0, 3, 40);
    wrReg(1, 0, 3);  wrReg(1, 1, 0);
    accessCk(2, 0, 1'b0, 30, "R4");
    accessCk(0, 1, 1'b0, 10, "R4");
    accessCk(1, 1, 1'b0, 20, "R4");
    accessCk(2, 1, 1'b0, 33, "R4");
    accessCk(3, 1, 1'b0, 40, "R4");

    // R9: idle cycles leave pointers unchanged
    repeat (20) @(posedge clk);
    accessCk(0, 1, 1'b0, 10, "R9");
    accessCk(1, 1, 1'b0, 20, "R9");
    accessCk(2, 1, 1'b0, 33, "R9");
    accessCk(3, 1, 1'b0, 40, "R9");

    // R8: pointer write and access on the same slot in one cycle
    @(negedge clk);
    wrEn = 1'b1; wrKind = 2'd0; wrIdx = 2'd1; wrData = 8'd99;
    accEn = 1'b1; accIdx = 2'd1; modIdx = 2'd0;
    #1 check("R8", addr, 20);
    @(posedge clk); #1;
    wrEn = 1'b0; accEn = 1'b0;
    accessCk(1, 1, 1'b0, 99, "R8");

    // R7: reversed emission, stored pointer stays unreversed
    for (int p = 0; p < 256; p++) begin
      wrReg(0, 3, p);
      accessCk(3, 1, 1'b1, revExp(p), "R7");
      accessCk(3, 1, 1'b0, p, "R7");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule